// File: doc/BRIEF.md
# DSP Extension-Field Decoder and Executor

This block takes the low byte of a 16-bit DSP instruction word, treats it as an extension operation attached to the main instruction, and carries out its side effects. Those side effects are address-register adjustments, moves between register banks, stores to data memory, single loads and dual loads. None of them touch the program counter. Decoding the main instruction is done elsewhere. The surrounding pipeline pulses a prologue strobe and, for the combined store/load forms, an epilogue strobe. The block answers each strobe with a one-cycle done pulse.

Addresses are not held here. The current address-register values arrive on `ar_val`, and each pointer change leaves the block as a per-register command on `ar_cmd` for an external address-register unit to apply. Source words, which are the low and middle accumulator words, arrive on `src_words`. Loaded and moved values leave on two register write ports that point into an eight-entry auxiliary bank. Data memory is reached through one write port and two synchronous read ports. Read data comes back one cycle after the request, and the register write is committed on the following cycle.

Top module: `dsp_ext_unit`

## Requirements
- R1: When `ext_op` is 8'h00, a strobe produces no memory request, no `ar_cmd` and no register write. Only the matching done pulse appears, one cycle after the strobe.
- R2: Group `ext_op[7:4]`=0 acts in the prologue on address register `ext_op[1:0]`. `ext_op[3:2]` selects the action: 0 clear, 1 decrement, 2 increment, 3 add index. The matching `ar_cmd` codes are 1 clear, 2 decrement, 3 increment and 4 add index, with 0 meaning no change. The field for register n sits at `ar_cmd[3n+2:3n]`. The command appears one cycle after the strobe.
- R3: Group 1 (move) writes port 0, one cycle after the strobe. The select is {0,`ext_op[3:2]`} and the data is source word `ext_op[1:0]`, where word k is `src_words[16k+15:16k]`.
- R4: Groups 2 and 3 (store) write source word `ext_op[4:3]` to the address held in register `ext_op[1:0]`. That register then receives add-index if `ext_op[2]` is set, otherwise increment.
- R5: Groups 4 to 7 (load) issue a port-0 read at the address held in register `ext_op[1:0]`, together with its pointer command (add-index if `ext_op[2]`, otherwise increment). Two cycles later the read word is written through port 0 with select `ext_op[5:3]`.
- R6: Groups C to F (dual load) read through register `ext_op[1:0]` on port 0 into select {0,`ext_op[5]`,0}, and through register 3 on port 1 into select {0,`ext_op[4]`,1}. `ext_op[2]` picks add-index for the first pointer and `ext_op[3]` picks it for register 3; a clear bit means increment. When `ext_op[1:0]`=3, the register-3 command follows `ext_op[3]`.
- R7: Groups 8 to B, prologue: source word 2+`ext_op[0]` is stored. If `ext_op[1]`=1 the store goes through register 0, whose command follows `ext_op[2]`. Otherwise it goes through register 3, whose command follows `ext_op[3]`. No read is issued.
- R8: Groups 8 to B, epilogue: a load goes through the other pointer (register 3 with `ext_op[3]` if `ext_op[1]`=1, else register 0 with `ext_op[2]`). It uses port 0 and writes select {0,`ext_op[5:4]`}.
- R9: An epilogue strobe for any group outside 8 to B has no effect except `epi_done`.
- R10: `pro_done` or `epi_done` pulses for one cycle. It comes one cycle after the strobe when no read is involved, and three cycles after the strobe when a read is involved.
- R11: Strobes that arrive while a read is in flight are ignored. When both strobes are high together, only the prologue runs.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_op | input | 8 | Extension field of the current instruction |
| pro_go | input | 1 | Prologue request strobe |
| epi_go | input | 1 | Epilogue request strobe |
| ar_val | input | 4*AW | Current values of address registers 0..3 |
| src_words | input | 4*DW | Accumulator source words 0..3 (words 2,3 are the middle words) |
| mem_wr_en | output | 1 | Data memory write enable |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| mem_rd0_en | output | 1 | Read port 0 request |
| mem_rd0_addr | output | AW | Read port 0 address |
| mem_rd0_data | input | DW | Read port 0 data, one cycle after request |
| mem_rd1_en | output | 1 | Read port 1 request |
| mem_rd1_addr | output | AW | Read port 1 address |
| mem_rd1_data | input | DW | Read port 1 data, one cycle after request |
| ar_cmd | output | 12 | Per-register update commands, 3 bits each |
| reg_wr0_en | output | 1 | Auxiliary bank write port 0 enable |
| reg_wr0_sel | output | 3 | Port 0 destination select |
| reg_wr0_data | output | DW | Port 0 data |
| reg_wr1_en | output | 1 | Auxiliary bank write port 1 enable |
| reg_wr1_sel | output | 3 | Port 1 destination select |
| reg_wr1_data | output | DW | Port 1 data |
| pro_done | output | 1 | Prologue complete pulse |
| epi_done | output | 1 | Epilogue complete pulse |

## Verification
The bench targets the all-zero field. A design that decodes it as group 0 would clear register 0. It also exercises a dual load whose first pointer is register 3. There, a wrong merge would emit the first pointer's command, or two conflicting ones, on the register-3 field. It strikes with strobes during the two in-flight cycles of a load, and with both strobes at once. A design without the busy guard would issue a second request or overwrite the pending destination. Finally, it issues epilogues on non-combined groups and prologues on combined groups. A phase mix-up there would show as a stray store, or as a read in the wrong phase.

// File: rtl/dsp_ext_pkg.sv
package dsp_ext_pkg;
  localparam int EXT_W  = 8;
  localparam int NUM_AR = 4;
  localparam int CMD_W  = 3;
  localparam int SEL_W  = 3;
  localparam int PTR_W  = $clog2(NUM_AR);

  typedef enum logic [CMD_W-1:0] {
    AR_NOP   = 3'd0,
    AR_CLR   = 3'd1,
    AR_DEC   = 3'd2,
    AR_INC   = 3'd3,
    AR_ADDIX = 3'd4
  } ar_cmd_e;

  typedef struct packed {
    logic                             wr;
    logic [PTR_W-1:0]                 wr_ar;
    logic [PTR_W-1:0]                 wr_src;
    logic                             rd0;
    logic [PTR_W-1:0]                 rd0_ar;
    logic [SEL_W-1:0]                 rd0_dst;
    logic                             rd1;
    logic [SEL_W-1:0]                 rd1_dst;
    logic                             mv;
    logic [SEL_W-1:0]                 mv_dst;
    logic [PTR_W-1:0]                 mv_src;
    logic [NUM_AR-1:0][CMD_W-1:0]     cmd;
  } ext_act_t;

  function automatic logic [CMD_W-1:0] step_cmd(input logic use_ix);
    return use_ix ? AR_ADDIX : AR_INC;
  endfunction
endpackage

// File: rtl/dsp_ext_decode.sv
module dsp_ext_decode
  import dsp_ext_pkg::*;
(
  input  logic [EXT_W-1:0] op,
  input  logic             epi,
  output ext_act_t         act
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_AR-1);

  always_comb begin
    act = '0;
    if (op != '0) begin
      case (op[7:4])
        4'h0: if (!epi) act.cmd[op[1:0]] = {1'b0, op[3:2]} + 3'd1;
        4'h1: if (!epi) begin
          act.mv     = 1'b1;
          act.mv_src = op[1:0];
          act.mv_dst = {1'b0, op[3:2]};
        end
        4'h2, 4'h3: if (!epi) begin
          act.wr             = 1'b1;
          act.wr_ar          = op[1:0];
          act.wr_src         = op[4:3];
          act.cmd[op[1:0]]   = step_cmd(op[2]);
        end
        4'h4, 4'h5, 4'h6, 4'h7: if (!epi) begin
          act.rd0            = 1'b1;
          act.rd0_ar         = op[1:0];
          act.rd0_dst        = op[5:3];
          act.cmd[op[1:0]]   = step_cmd(op[2]);
        end
        4'h8, 4'h9, 4'hA, 4'hB: begin
          if (!epi) begin
            act.wr     = 1'b1;
            act.wr_src = {1'b1, op[0]};
            if (op[1]) begin
              act.wr_ar  = '0;
              act.cmd[0] = step_cmd(op[2]);
            end else begin
              act.wr_ar         = PTR_LAST;
              act.cmd[PTR_LAST] = step_cmd(op[3]);
            end
          end else begin
            act.rd0     = 1'b1;
            act.rd0_dst = {1'b0, op[5:4]};
            if (op[1]) begin
              act.rd0_ar        = PTR_LAST;
              act.cmd[PTR_LAST] = step_cmd(op[3]);
            end else begin
              act.rd0_ar = '0;
              act.cmd[0] = step_cmd(op[2]);
            end
          end
        end
        default: if (!epi) begin
          act.rd0              = 1'b1;
          act.rd0_ar           = op[1:0];
          act.rd0_dst          = {1'b0, op[5], 1'b0};
          act.rd1              = 1'b1;
          act.rd1_dst          = {1'b0, op[4], 1'b1};
          act.cmd[op[1:0]]     = step_cmd(op[2]);
          act.cmd[PTR_LAST]    = step_cmd(op[3]);  // second pointer rule wins (R6)
        end
      endcase
    end
  end
endmodule

// File: rtl/dsp_ext_issue.sv
module dsp_ext_issue
  import dsp_ext_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          accept,
  input  logic                          do_wr,
  input  logic                          do_rd0,
  input  logic                          do_rd1,
  input  logic [NUM_AR-1:0][CMD_W-1:0]  cmd,
  input  logic [AW-1:0]                 wr_addr_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic [AW-1:0]                 rd0_addr_i,
  input  logic [AW-1:0]                 rd1_addr_i,
  output logic                          mem_wr_en,
  output logic [AW-1:0]                 mem_wr_addr,
  output logic [DW-1:0]                 mem_wr_data,
  output logic                          mem_rd0_en,
  output logic [AW-1:0]                 mem_rd0_addr,
  output logic                          mem_rd1_en,
  output logic [AW-1:0]                 mem_rd1_addr,
  output logic [NUM_AR*CMD_W-1:0]       ar_cmd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_en    <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      mem_rd0_en   <= 1'b0;
      mem_rd0_addr <= '0;
      mem_rd1_en   <= 1'b0;
      mem_rd1_addr <= '0;
      ar_cmd       <= '0;
    end else begin
      mem_wr_en  <= accept & do_wr;
      mem_rd0_en <= accept & do_rd0;
      mem_rd1_en <= accept & do_rd1;
      ar_cmd     <= accept ? cmd : '0;
      if (accept) begin
        mem_wr_addr  <= wr_addr_i;
        mem_wr_data  <= wr_data_i;
        mem_rd0_addr <= rd0_addr_i;
        mem_rd1_addr <= rd1_addr_i;
      end
    end
  end
endmodule

// File: rtl/dsp_ext_commit.sv
module dsp_ext_commit
  import dsp_ext_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             epi,
  input  logic             do_rd0,
  input  logic             do_rd1,
  input  logic [SEL_W-1:0] rd0_dst,
  input  logic [SEL_W-1:0] rd1_dst,
  input  logic             do_mv,
  input  logic [SEL_W-1:0] mv_dst,
  input  logic [DW-1:0]    mv_data,
  input  logic [DW-1:0]    rd0_data,
  input  logic [DW-1:0]    rd1_data,
  output logic             reg_wr0_en,
  output logic [SEL_W-1:0] reg_wr0_sel,
  output logic [DW-1:0]    reg_wr0_data,
  output logic             reg_wr1_en,
  output logic [SEL_W-1:0] reg_wr1_sel,
  output logic [DW-1:0]    reg_wr1_data,
  output logic             pro_done,
  output logic             epi_done,
  output logic             busy
);
  logic             req_v, ret_v, p_epi, p_r0, p_r1;
  logic [SEL_W-1:0] p_d0, p_d1;

  assign busy = req_v | ret_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_v <= 1'b0; ret_v <= 1'b0; p_epi <= 1'b0; p_r0 <= 1'b0; p_r1 <= 1'b0;
      p_d0 <= '0; p_d1 <= '0;
      reg_wr0_en <= 1'b0; reg_wr0_sel <= '0; reg_wr0_data <= '0;
      reg_wr1_en <= 1'b0; reg_wr1_sel <= '0; reg_wr1_data <= '0;
      pro_done <= 1'b0; epi_done <= 1'b0;
    end else begin
      reg_wr0_en <= 1'b0;
      reg_wr1_en <= 1'b0;
      pro_done   <= 1'b0;
      epi_done   <= 1'b0;
      ret_v      <= req_v;
      req_v      <= 1'b0;
      if (accept) begin
        if (do_rd0 | do_rd1) begin
          req_v <= 1'b1;
          p_epi <= epi;
          p_r0  <= do_rd0;
          p_r1  <= do_rd1;
          p_d0  <= rd0_dst;
          p_d1  <= rd1_dst;
        end else begin
          pro_done <= ~epi;
          epi_done <= epi;
        end
        if (do_mv) begin
          reg_wr0_en   <= 1'b1;
          reg_wr0_sel  <= mv_dst;
          reg_wr0_data <= mv_data;
        end
      end
      if (ret_v) begin
        reg_wr0_en   <= p_r0;
        reg_wr0_sel  <= p_d0;
        reg_wr0_data <= rd0_data;
        reg_wr1_en   <= p_r1;
        reg_wr1_sel  <= p_d1;
        reg_wr1_data <= rd1_data;
        pro_done     <= ~p_epi;
        epi_done     <= p_epi;
      end
    end
  end

  assert_move_now_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && do_mv) |=> (reg_wr0_en && reg_wr0_sel == $past(mv_dst)));

  assert_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(pro_done && epi_done));
endmodule

// File: rtl/dsp_ext_unit.sv
module dsp_ext_unit
  import dsp_ext_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [EXT_W-1:0]        ext_op,
  input  logic                    pro_go,
  input  logic                    epi_go,
  input  logic [NUM_AR*AW-1:0]    ar_val,
  input  logic [NUM_AR*DW-1:0]    src_words,
  output logic                    mem_wr_en,
  output logic [AW-1:0]           mem_wr_addr,
  output logic [DW-1:0]           mem_wr_data,
  output logic                    mem_rd0_en,
  output logic [AW-1:0]           mem_rd0_addr,
  input  logic [DW-1:0]           mem_rd0_data,
  output logic                    mem_rd1_en,
  output logic [AW-1:0]           mem_rd1_addr,
  input  logic [DW-1:0]           mem_rd1_data,
  output logic [NUM_AR*CMD_W-1:0] ar_cmd,
  output logic                    reg_wr0_en,
  output logic [SEL_W-1:0]        reg_wr0_sel,
  output logic [DW-1:0]           reg_wr0_data,
  output logic                    reg_wr1_en,
  output logic [SEL_W-1:0]        reg_wr1_sel,
  output logic [DW-1:0]           reg_wr1_data,
  output logic                    pro_done,
  output logic                    epi_done
);
  logic [AW-1:0] arv  [NUM_AR];
  logic [DW-1:0] srcv [NUM_AR];

  for (genvar i = 0; i < NUM_AR; i++) begin : g_unpack
    assign arv[i]  = ar_val[i*AW +: AW];
    assign srcv[i] = src_words[i*DW +: DW];
  end

  ext_act_t act;
  logic     busy, phase_epi, accept;

  // Prologue wins when both strobes arrive together (R11)
  assign phase_epi = ~pro_go;
  assign accept    = (pro_go | epi_go) & ~busy;

  dsp_ext_decode u_decode (
    .op  (ext_op),
    .epi (phase_epi),
    .act (act)
  );

  dsp_ext_issue #(.DW(DW), .AW(AW)) u_issue (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .do_wr        (act.wr),
    .do_rd0       (act.rd0),
    .do_rd1       (act.rd1),
    .cmd          (act.cmd),
    .wr_addr_i    (arv[act.wr_ar]),
    .wr_data_i    (srcv[act.wr_src]),
    .rd0_addr_i   (arv[act.rd0_ar]),
    .rd1_addr_i   (arv[NUM_AR-1]),
    .mem_wr_en    (mem_wr_en),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_rd0_en   (mem_rd0_en),
    .mem_rd0_addr (mem_rd0_addr),
    .mem_rd1_en   (mem_rd1_en),
    .mem_rd1_addr (mem_rd1_addr),
    .ar_cmd       (ar_cmd)
  );

  dsp_ext_commit #(.DW(DW)) u_commit (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .epi          (phase_epi),
    .do_rd0       (act.rd0),
    .do_rd1       (act.rd1),
    .rd0_dst      (act.rd0_dst),
    .rd1_dst      (act.rd1_dst),
    .do_mv        (act.mv),
    .mv_dst       (act.mv_dst),
    .mv_data      (srcv[act.mv_src]),
    .rd0_data     (mem_rd0_data),
    .rd1_data     (mem_rd1_data),
    .reg_wr0_en   (reg_wr0_en),
    .reg_wr0_sel  (reg_wr0_sel),
    .reg_wr0_data (reg_wr0_data),
    .reg_wr1_en   (reg_wr1_en),
    .reg_wr1_sel  (reg_wr1_sel),
    .reg_wr1_data (reg_wr1_data),
    .pro_done     (pro_done),
    .epi_done     (epi_done),
    .busy         (busy)
  );

  assert_zero_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (pro_go && !busy && ext_op == '0) |=>
      (ar_cmd == '0 && !mem_wr_en && !mem_rd0_en && !mem_rd1_en && !reg_wr0_en && pro_done));

  for (genvar k = 0; k < NUM_AR; k++) begin : g_cmd_chk
    assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (rst)
      ar_cmd[k*CMD_W +: CMD_W] <= 3'd4);
  end

  assert_store_done_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (pro_done && !epi_done && !mem_rd0_en));

  assert_load_commit_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd0_en |=> ##1 (reg_wr0_en && (pro_done || epi_done)));

  assert_dual_pair_R6: assert property (@(posedge clk) disable iff (rst)
    reg_wr1_en |-> (reg_wr0_en && reg_wr1_sel[0] && !reg_wr0_sel[0]));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd0_en |=> (!mem_rd0_en && !mem_wr_en && ar_cmd == '0));
endmodule

// File: tb/tb_dsp_ext_unit.sv
`timescale 1ns/1ps
module tb_dsp_ext_unit;
  localparam int DW = 16;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [7:0] ext_op;
  logic pro_go, epi_go;
  logic [4*AW-1:0] ar_val;
  logic [4*DW-1:0] src_words;
  logic mem_wr_en, mem_rd0_en, mem_rd1_en;
  logic [AW-1:0] mem_wr_addr, mem_rd0_addr, mem_rd1_addr;
  logic [DW-1:0] mem_wr_data, mem_rd0_data, mem_rd1_data;
  logic [11:0] ar_cmd;
  logic reg_wr0_en, reg_wr1_en, pro_done, epi_done;
  logic [2:0] reg_wr0_sel, reg_wr1_sel;
  logic [DW-1:0] reg_wr0_data, reg_wr1_data;

  always #4 clk = ~clk;

  dsp_ext_unit #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .ext_op(ext_op), .pro_go(pro_go), .epi_go(epi_go),
    .ar_val(ar_val), .src_words(src_words),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd0_en(mem_rd0_en), .mem_rd0_addr(mem_rd0_addr), .mem_rd0_data(mem_rd0_data),
    .mem_rd1_en(mem_rd1_en), .mem_rd1_addr(mem_rd1_addr), .mem_rd1_data(mem_rd1_data),
    .ar_cmd(ar_cmd),
    .reg_wr0_en(reg_wr0_en), .reg_wr0_sel(reg_wr0_sel), .reg_wr0_data(reg_wr0_data),
    .reg_wr1_en(reg_wr1_en), .reg_wr1_sel(reg_wr1_sel), .reg_wr1_data(reg_wr1_data),
    .pro_done(pro_done), .epi_done(epi_done)
  );

  // environment memory: synchronous, one cycle read latency
  logic [15:0] mem  [256];
  logic [15:0] rmem [256];
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_wr_addr[7:0]] <= mem_wr_data;
    if (mem_rd0_en) mem_rd0_data <= mem[mem_rd0_addr[7:0]];
    if (mem_rd1_en) mem_rd1_data <= mem[mem_rd1_addr[7:0]];
  end

  typedef struct {
    bit wr; logic [15:0] wa; logic [15:0] wd;
    bit r0; logic [15:0] r0a;
    bit r1; logic [15:0] r1a;
    logic [11:0] cmd;
    bit g0; logic [2:0] s0; logic [15:0] d0;
    bit g1; logic [2:0] s1; logic [15:0] d1;
    bit pd; bit ed;
    int tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, idle_tag = 12;
  logic [15:0] arv [4];
  logic [15:0] srcw [4];

  function automatic exp_t idle(int t);
    exp_t e;
    e.wr = 0; e.wa = '0; e.wd = '0; e.r0 = 0; e.r0a = '0; e.r1 = 0; e.r1a = '0;
    e.cmd = '0; e.g0 = 0; e.s0 = '0; e.d0 = '0; e.g1 = 0; e.s1 = '0; e.d1 = '0;
    e.pd = 0; e.ed = 0; e.tag = t;
    return e;
  endfunction

  function automatic logic [2:0] stp(bit b);
    return b ? 3'd4 : 3'd3;
  endfunction

  task automatic chk(bit ok, int tag, string what, logic [31:0] a, logic [31:0] x);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, a, x);
    end
  endtask

  task automatic compare(exp_t e);
    chk(mem_wr_en === e.wr, e.tag, "mem_wr_en", 32'(mem_wr_en), 32'(e.wr));
    if (e.wr) begin
      chk(mem_wr_addr === e.wa, e.tag, "mem_wr_addr", 32'(mem_wr_addr), 32'(e.wa));
      chk(mem_wr_data === e.wd, e.tag, "mem_wr_data", 32'(mem_wr_data), 32'(e.wd));
    end
    chk(mem_rd0_en === e.r0, e.tag, "mem_rd0_en", 32'(mem_rd0_en), 32'(e.r0));
    if (e.r0) chk(mem_rd0_addr === e.r0a, e.tag, "mem_rd0_addr", 32'(mem_rd0_addr), 32'(e.r0a));
    chk(mem_rd1_en === e.r1, e.tag, "mem_rd1_en", 32'(mem_rd1_en), 32'(e.r1));
    if (e.r1) chk(mem_rd1_addr === e.r1a, e.tag, "mem_rd1_addr", 32'(mem_rd1_addr), 32'(e.r1a));
    chk(ar_cmd === e.cmd, e.tag, "ar_cmd", 32'(ar_cmd), 32'(e.cmd));
    chk(reg_wr0_en === e.g0, e.tag, "reg_wr0_en", 32'(reg_wr0_en), 32'(e.g0));
    if (e.g0) begin
      chk(reg_wr0_sel === e.s0, e.tag, "reg_wr0_sel", 32'(reg_wr0_sel), 32'(e.s0));
      chk(reg_wr0_data === e.d0, e.tag, "reg_wr0_data", 32'(reg_wr0_data), 32'(e.d0));
    end
    chk(reg_wr1_en === e.g1, e.tag, "reg_wr1_en", 32'(reg_wr1_en), 32'(e.g1));
    if (e.g1) begin
      chk(reg_wr1_sel === e.s1, e.tag, "reg_wr1_sel", 32'(reg_wr1_sel), 32'(e.s1));
      chk(reg_wr1_data === e.d1, e.tag, "reg_wr1_data", 32'(reg_wr1_data), 32'(e.d1));
    end
    chk(pro_done === e.pd, e.tag, "pro_done (R10)", 32'(pro_done), 32'(e.pd));
    chk(epi_done === e.ed, e.tag, "epi_done (R10)", 32'(epi_done), 32'(e.ed));
  endtask

  task automatic tick();
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = idle(idle_tag);
    compare(e);
  endtask

  // behavioural reference: expected outputs for the cycles after a strobe
  function automatic void model(logic [7:0] op, bit epi, int ftag);
    exp_t e0, e1, e2;
    int tag, p;
    bit ld = 0;
    logic [3:0] g = op[7:4];
    if (op == 8'h00) tag = 1;
    else if (g == 0) tag = 2;
    else if (g == 1) tag = 3;
    else if (g < 4) tag = 4;
    else if (g < 8) tag = 5;
    else if (g < 12) tag = epi ? 8 : 7;
    else tag = 6;
    if (epi && op != 8'h00 && (g < 8 || g > 11)) tag = 9;
    if (ftag != 0) tag = ftag;
    e0 = idle(tag); e1 = idle(tag); e2 = idle(tag);
    if (op != 8'h00 && !epi) begin
      if (g == 0) begin
        p = int'(op[1:0]);
        e0.cmd[3*p +: 3] = {1'b0, op[3:2]} + 3'd1;
      end else if (g == 1) begin
        e0.g0 = 1; e0.s0 = {1'b0, op[3:2]}; e0.d0 = srcw[op[1:0]];
      end else if (g < 4) begin
        p = int'(op[1:0]);
        e0.wr = 1; e0.wa = arv[p]; e0.wd = srcw[op[4:3]];
        rmem[e0.wa[7:0]] = e0.wd;
        e0.cmd[3*p +: 3] = stp(op[2]);
      end else if (g < 8) begin
        p = int'(op[1:0]);
        e0.r0 = 1; e0.r0a = arv[p]; e0.cmd[3*p +: 3] = stp(op[2]);
        e2.g0 = 1; e2.s0 = op[5:3]; e2.d0 = rmem[arv[p][7:0]];
        ld = 1;
      end else if (g < 12) begin
        p = op[1] ? 0 : 3;
        e0.wr = 1; e0.wa = arv[p]; e0.wd = srcw[{1'b1, op[0]}];
        rmem[e0.wa[7:0]] = e0.wd;
        e0.cmd[3*p +: 3] = stp(op[1] ? op[2] : op[3]);
      end else begin
        p = int'(op[1:0]);
        e0.r0 = 1; e0.r0a = arv[p]; e0.r1 = 1; e0.r1a = arv[3];
        e0.cmd[3*p +: 3] = stp(op[2]);
        e0.cmd[9 +: 3] = stp(op[3]);
        e2.g0 = 1; e2.s0 = {1'b0, op[5], 1'b0}; e2.d0 = rmem[arv[p][7:0]];
        e2.g1 = 1; e2.s1 = {1'b0, op[4], 1'b1}; e2.d1 = rmem[arv[3][7:0]];
        ld = 1;
      end
    end else if (op != 8'h00 && epi && g >= 8 && g < 12) begin
      p = op[1] ? 3 : 0;
      e0.r0 = 1; e0.r0a = arv[p];
      e0.cmd[3*p +: 3] = stp(op[1] ? op[3] : op[2]);
      e2.g0 = 1; e2.s0 = {1'b0, op[5:4]}; e2.d0 = rmem[arv[p][7:0]];
      ld = 1;
    end
    if (ld) begin e2.pd = !epi; e2.ed = epi; end
    else begin e0.pd = !epi; e0.ed = epi; end
    q.push_back(e0);
    if (ld) begin q.push_back(e1); q.push_back(e2); end
  endfunction

  task automatic drive_ctx();
    ar_val    = {arv[3], arv[2], arv[1], arv[0]};
    src_words = {srcw[3], srcw[2], srcw[1], srcw[0]};
  endtask

  task automatic shuffle();
    for (int i = 0; i < 4; i++) begin
      arv[i]  = 16'($urandom_range(0, 255));
      srcw[i] = 16'($urandom);
    end
  endtask

  // mode: 0 prologue, 1 epilogue, 2 both strobes
  task automatic run_op(logic [7:0] op, int mode, int ftag);
    drive_ctx();
    ext_op = op;
    pro_go = (mode != 1);
    epi_go = (mode != 0);
    model(op, mode == 1, ftag);
    tick();
    pro_go = 0; epi_go = 0;
    while (q.size() > 0) tick();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'(i * 613 + 77);
      rmem[i] = 16'(i * 613 + 77);
    end
    rst = 1; ext_op = '0; pro_go = 0; epi_go = 0;
    arv = '{16'h10, 16'h20, 16'h30, 16'h40};
    srcw = '{16'hA001, 16'hB002, 16'hC003, 16'hD004};
    drive_ctx();
    // R12: outputs held at zero in reset and just after
    idle_tag = 12;
    repeat (3) tick();
    rst = 0;
    tick();
    idle_tag = 11;

    // R1: zero field does nothing but done
    run_op(8'h00, 0, 0);
    run_op(8'h00, 1, 0);
    // R2: address register actions on every register and subcode
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 4; r++) run_op(8'(s * 4 + r), 0, 0);
    // R3: moves
    run_op(8'h10, 0, 0); run_op(8'h1E, 0, 0); run_op(8'h17, 0, 0);
    // R4: stores, increment and add-index
    run_op(8'h20, 0, 0); run_op(8'h3D, 0, 0); run_op(8'h2A, 0, 0); run_op(8'h37, 0, 0);
    // R5: loads into all eight destinations
    for (int d = 0; d < 8; d++) run_op(8'h40 | 8'(d << 3) | 8'(d & 7) & 8'h07, 0, 0);
    // R6: dual loads, including first pointer = register 3
    run_op(8'hC0, 0, 0); run_op(8'hF5, 0, 0); run_op(8'hDB, 0, 0);
    run_op(8'hE7, 0, 0); run_op(8'hCF, 0, 0); run_op(8'hF3, 0, 0);
    // R7 / R8: combined forms in both orders
    run_op(8'h83, 0, 0); run_op(8'h83, 1, 0);
    run_op(8'hB8, 0, 0); run_op(8'hB8, 1, 0);
    run_op(8'h96, 0, 0); run_op(8'h96, 1, 0);
    run_op(8'hAD, 0, 0); run_op(8'hAD, 1, 0);
    // R9: epilogue on non-combined groups is empty
    run_op(8'h25, 1, 0); run_op(8'h4A, 1, 0); run_op(8'hD1, 1, 0); run_op(8'h0B, 1, 0);

    // R11: strobes during an in-flight load are ignored
    drive_ctx();
    ext_op = 8'h6D; pro_go = 1;
    model(8'h6D, 0, 11);
    tick();
    ext_op = 8'h21; epi_go = 1;
    tick();
    tick();
    pro_go = 0; epi_go = 0;
    tick();
    tick();
    // R11: both strobes -> prologue only
    run_op(8'h9A, 2, 11);
    run_op(8'h0E, 2, 11);

    // mixed traffic over all groups and phases (R2..R9)
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      int mode;
      shuffle();
      op = 8'($urandom);
      mode = ($urandom_range(0, 3) == 0) ? 1 : 0;
      run_op(op, mode, 0);
      if (op[7:6] == 2'b10 && mode == 0) run_op(op, 1, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule